// File: doc/BRIEF.md
# Debug Target Probe Sequencer

This controller sits one level above a serial debug frame master. It brings up a freshly connected target and identifies it. A single `start` pulse launches a fixed bring-up script:

- a line reset;
- two writes of an enable word to the debug control register;
- a throw-away read of the status register;
- a read of the identification register.

A programmable number of millisecond ticks must pass after each register write and after the status read before the next request goes out.

Each step goes to the frame master as one request. The request is held until the master answers with a one-cycle response carrying an ok flag and read data. Once the last response has arrived, the sequencer pulses `done`. It also presents the captured identifier, and decides whether a device answered by checking the identifier's low bits against the all-ones pattern that a floating bus returns. A frame that fails is never retried. The script always runs to its end, and a failed identification read reports no device.

Top module: `probe_seq`

## Requirements
- R1: After reset, `done`, `present`, `req_valid` and `chip_id` are all 0.
- R2: The first request after an accepted `start` is a line reset. Kind codes on `req_kind` are 0 for line reset, 1 for register write and 2 for register read.
- R3: The second and third requests are writes of `ENABLE_WORD` (0x80000001) to `CTRL_ADDR` (0x10). After each write's response, `req_valid` stays low until exactly `GAP_TICKS` `ms_tick` pulses have been sampled.
- R4: The fourth request reads `STAT_ADDR` (0x11). Its returned data never reaches `chip_id`, and it is followed by the same tick gap as in R3.
- R5: The fifth and last request reads `ID_ADDR` (0x7F). When its response has ok set, the returned word appears on `chip_id`; otherwise `chip_id` stays 0.
- R6: `present` is 1 only when the identification read returned ok and bits [14:0] of the returned word are not 0x7FFF.
- R7: In the cycle after an accepted `start`, `chip_id` and `present` read 0.
- R8: Each script step is requested exactly once. A failed response (`rsp_ok` = 0) on any step causes no retry, and the script carries on to its last step.
- R9: `done` is high for exactly one cycle, in the cycle after the final response, and `chip_id`/`present` are valid in that cycle.
- R10: A `start` pulse that arrives while a probe is running is ignored, and the script continues from where it was.
- R11: `req_valid`, `req_kind`, `req_addr` and `req_wdata` hold steady until `rsp_valid` is seen, and `req_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a probe; only acted on when idle |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| req_valid | output | 1 | Request outstanding to the frame master |
| req_kind | output | 2 | 0 line reset, 1 write, 2 read |
| req_addr | output | ADDR_W | Debug register address |
| req_wdata | output | DATA_W | Write data (0 for reads and line reset) |
| rsp_valid | input | 1 | One-cycle response from the frame master |
| rsp_ok | input | 1 | Frame completed without error |
| rsp_rdata | input | DATA_W | Read data for read requests |
| done | output | 1 | One-cycle pulse when the script ends |
| present | output | 1 | Device detected |
| chip_id | output | DATA_W | Captured identification word |

## Verification
The assertions assume that the frame master raises `rsp_valid` only while a request is outstanding, and for a single cycle per request. They also assume that `ms_tick` arrives as isolated one-cycle pulses. The bench's master model waits for `req_valid`, idles for zero to three cycles and then answers once. Its tick generator spaces pulses at least three cycles apart, so no tick can fall between the timer's expiry and the next request. A stray `start` is injected during a running probe, because the design must tolerate that input at any time.

// File: rtl/probe_pkg.sv
package probe_pkg;

  typedef enum logic [1:0] {
    KIND_LINE_RESET = 2'd0,
    KIND_WRITE      = 2'd1,
    KIND_READ       = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_GAP
  } seq_state_e;

  localparam int NUM_STEPS = 5;

endpackage

// File: rtl/probe_script.sv
module probe_script
  import probe_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int STEP_W = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 'h11,
  parameter logic [ADDR_W-1:0] ID_ADDR     = 'h7F,
  parameter logic [DATA_W-1:0] ENABLE_WORD = 'h8000_0001
) (
  input  logic [STEP_W-1:0] step,
  output logic [1:0]        kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              gap_after,
  output logic              last
);

  always_comb begin
    kind      = KIND_LINE_RESET;
    addr      = '0;
    wdata     = '0;
    gap_after = 1'b0;
    last      = 1'b0;
    case (step)
      STEP_W'(1), STEP_W'(2): begin
        kind      = KIND_WRITE;
        addr      = CTRL_ADDR;
        wdata     = ENABLE_WORD;
        gap_after = 1'b1;
      end
      STEP_W'(3): begin
        kind      = KIND_READ;
        addr      = STAT_ADDR;
        gap_after = 1'b1;
      end
      STEP_W'(4): begin
        kind = KIND_READ;
        addr = ID_ADDR;
        last = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int GAP_TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic expired
);

  localparam int CNT_W = $clog2(GAP_TICKS + 1);

  logic [CNT_W-1:0] remain;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      armed   <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        remain <= CNT_W'(GAP_TICKS);
        armed  <= 1'b1;
      end else if (armed && tick) begin
        if (remain == CNT_W'(1)) begin
          armed   <= 1'b0;
          expired <= 1'b1;
        end else begin
          remain <= remain - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/probe_seq.sv
module probe_seq
  import probe_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int ID_MASK_W = 15,
  parameter int GAP_TICKS = 1,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 'h11,
  parameter logic [ADDR_W-1:0] ID_ADDR     = 'h7F,
  parameter logic [DATA_W-1:0] ENABLE_WORD = 'h8000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ms_tick,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              done,
  output logic              present,
  output logic [DATA_W-1:0] chip_id
);

  localparam int STEP_W = $clog2(NUM_STEPS);

  seq_state_e        state;
  logic [STEP_W-1:0] step;
  logic [1:0]        rom_kind;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_wdata;
  logic              rom_gap;
  logic              rom_last;
  logic              gap_load;
  logic              gap_done;
  logic              busy;
  logic              in_gap;

  probe_script #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR), .ID_ADDR(ID_ADDR),
    .ENABLE_WORD(ENABLE_WORD)
  ) u_script (
    .step(step), .kind(rom_kind), .addr(rom_addr), .wdata(rom_wdata),
    .gap_after(rom_gap), .last(rom_last)
  );

  assign gap_load = (state == ST_WAIT) && rsp_valid && !rom_last && rom_gap;

  gap_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .tick(ms_tick), .expired(gap_done)
  );

  assign busy   = (state != ST_IDLE);
  assign in_gap = (state == ST_GAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= '0;
      req_valid <= 1'b0;
      req_kind  <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      done      <= 1'b0;
      present   <= 1'b0;
      chip_id   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            step    <= '0;
            chip_id <= '0;
            present <= 1'b0;
            state   <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          req_valid <= 1'b1;
          req_kind  <= rom_kind;
          req_addr  <= rom_addr;
          req_wdata <= rom_wdata;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            req_valid <= 1'b0;
            if (rom_last) begin
              done    <= 1'b1;
              state   <= ST_IDLE;
              present <= rsp_ok && (rsp_rdata[ID_MASK_W-1:0] != '1);
              if (rsp_ok) chip_id <= rsp_rdata;
            end else begin
              step  <= step + STEP_W'(1);
              state <= rom_gap ? ST_GAP : ST_LAUNCH;
            end
          end
        end
        ST_GAP: begin
          if (gap_done) state <= ST_LAUNCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/probe_seq_chk.sv
module probe_seq_chk
  import probe_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int ID_MASK_W = 15,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h10,
  parameter logic [DATA_W-1:0] ENABLE_WORD = 'h8000_0001
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              done,
  input logic              present,
  input logic [DATA_W-1:0] chip_id,
  input logic              busy,
  input logic              in_gap
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !rsp_valid |=> req_valid && $stable(req_kind) && $stable(req_addr) && $stable(req_wdata)); // R11

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    req_valid && rsp_valid |=> !req_valid); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid && !busy); // R9

  AST_PRESENT_MASK: assert property (@(posedge clk) disable iff (rst)
    present |-> chip_id[ID_MASK_W-1:0] != '1); // R6

  AST_WRITE_WORD: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_kind == KIND_WRITE |-> req_addr == CTRL_ADDR && req_wdata == ENABLE_WORD); // R3

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_gap |-> !req_valid); // R3

  AST_ID_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> chip_id == '0 && !present); // R7

endmodule

bind probe_seq probe_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_MASK_W(ID_MASK_W),
  .CTRL_ADDR(CTRL_ADDR), .ENABLE_WORD(ENABLE_WORD)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .done(done), .present(present), .chip_id(chip_id),
  .busy(busy), .in_gap(in_gap)
);

// File: tb/tb_probe_seq.sv
module tb_probe_seq;
  import probe_pkg::*;

  localparam int ADDR_W = 7;
  localparam int BGAP   = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic              ms_tick;
  logic              req_valid;
  logic [1:0]        req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              rsp_valid;
  logic              rsp_ok;
  logic [31:0]       rsp_rdata;
  logic              done;
  logic              present;
  logic [31:0]       chip_id;

  int checks = 0;
  int fails  = 0;
  int tick_per = 2;

  probe_seq #(.GAP_TICKS(BGAP)) dut (
    .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_rdata(rsp_rdata), .done(done), .present(present), .chip_id(chip_id)
  );

  always #5 clk = ~clk;

  initial begin
    ms_tick = 1'b0;
    forever begin
      repeat (tick_per) @(posedge clk);
      #1 ms_tick = 1'b1;
      @(posedge clk);
      #1 ms_tick = 1'b0;
    end
  end

  function automatic logic [1:0] exp_kind(input int i);
    if (i == 0) return 2'd0;
    if (i <= 2) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input int i);
    case (i)
      1, 2: return 7'h10;
      3: return 7'h11;
      4: return 7'h7F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [31:0] exp_wdata(input int i);
    return (i == 1 || i == 2) ? 32'h8000_0001 : 32'h0;
  endfunction

  function automatic bit exp_present(input bit ok, input logic [31:0] id);
    return ok && (id[14:0] != 15'h7FFF);
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic run_probe(input bit [4:0] ok_mask, input logic [31:0] id,
                           input bit poke_start);
    int ticks;
    int quiet_bad;
    int d;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    check(chip_id == 0 && present == 1'b0, "R7", "cleared at start", chip_id, 0);
    for (int i = 0; i < 5; i++) begin
      while (!req_valid) @(negedge clk);
      check(req_kind == exp_kind(i), poke_start ? "R2 R10" : "R2", "kind", 32'(req_kind), 32'(exp_kind(i)));
      check(req_addr == exp_addr(i), i == 4 ? "R5" : "R3 R4", "addr", 32'(req_addr), 32'(exp_addr(i)));
      check(req_wdata == exp_wdata(i), "R3", "wdata", req_wdata, exp_wdata(i));
      if (poke_start && i == 2) begin
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
      end
      d = $urandom % 4;
      repeat (d) @(posedge clk);
      @(posedge clk); #1;
      check(req_valid && req_addr == exp_addr(i), "R11", "held request", 32'(req_addr), 32'(exp_addr(i)));
      rsp_valid = 1'b1;
      rsp_ok    = ok_mask[i];
      rsp_rdata = (i == 4) ? id : $urandom;
      @(posedge clk); #1;
      rsp_valid = 1'b0;
      rsp_rdata = $urandom;
      @(negedge clk);
      check(!req_valid, "R11", "drop after response", 32'(req_valid), 0);
      if (i < 4) begin
        check(!done, "R9", "no early done", 32'(done), 0);
        if (i == 3)
          check(chip_id == 0, "R4", "status data discarded", chip_id, 0);
        if (i >= 1) begin
          ticks = 0;
          while (!req_valid) begin
            if (ms_tick) ticks++;
            @(negedge clk);
          end
          check(ticks == BGAP, i == 3 ? "R4" : "R3", "gap ticks", ticks, BGAP);
        end
      end else begin
        check(done, "R9", "done pulse", 32'(done), 1);
        check(present == exp_present(ok_mask[4], id), "R6", "present",
              32'(present), 32'(exp_present(ok_mask[4], id)));
        check(chip_id == (ok_mask[4] ? id : 32'h0), "R5", "chip id",
              chip_id, ok_mask[4] ? id : 32'h0);
        @(negedge clk);
        check(!done, "R9", "done single cycle", 32'(done), 0);
        quiet_bad = 0;
        repeat (15) begin
          if (req_valid || done) quiet_bad++;
          @(negedge clk);
        end
        check(quiet_bad == 0, "R8", "no retry after script", quiet_bad, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    bit [4:0] okm;
    logic [31:0] idv;
    void'($urandom(32'd4711));
    rst = 1'b1; start = 1'b0; rsp_valid = 1'b0; rsp_ok = 1'b0; rsp_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!done && !present && !req_valid && chip_id == 0, "R1", "reset state",
          {done, present, req_valid, chip_id[28:0]}, 0);
    // directed corner cases
    run_probe(5'b11111, 32'h1234_5678, 1'b0);
    run_probe(5'b11111, 32'hABCD_7FFF, 1'b0);
    run_probe(5'b11111, 32'h0000_7FFE, 1'b0);
    run_probe(5'b01111, 32'h0BAD_0001, 1'b0);  // R8 failed id read
    run_probe(5'b10101, 32'h5555_1234, 1'b0);  // R8 failed writes continue
    run_probe(5'b11111, 32'h0F0F_0F0F, 1'b1);  // R10 stray start
    // random mix
    for (int n = 0; n < 20; n++) begin
      tick_per = 2 + ($urandom % 4);
      for (int b = 0; b < 5; b++) okm[b] = ($urandom % 4) != 0;
      idv = $urandom;
      if ($urandom % 3 == 0) idv[14:0] = 15'h7FFF;
      run_probe(okm, idv, ($urandom % 4) == 0);
    end
    report();
    $finish;
  end

endmodule